// File: doc/BRIEF.md
# Packed Sub-Word Add/Subtract Unit

This unit adds or subtracts two 64-bit words that each hold several small integers packed side by side. A run-time select splits the word into eight 8-bit, four 16-bit or two 32-bit elements. Each element pair is combined on its own. No carry or borrow ever crosses from one element into the next.

Each element can either wrap around on overflow or clamp to the limit of its range. When clamping, the elements can be read as unsigned or as two's-complement signed numbers. A request is presented with a valid strobe. The packed result appears on a registered output one clock later, together with an output valid. Typical users are media and signal-processing datapaths that work on many narrow samples at once.

Top module: `simd_packed_alu`

## Requirements
- R1: `lane_sel` sets the element width: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Elements sit at consecutive bit positions starting at bit 0. No carry or borrow passes between elements.
- R2: `opcode` 0 computes a plus b for each element. `opcode` 1 computes a minus b for each element.
- R3: With `sat_en` 0, each element result is the low bits of the exact sum or difference, taken modulo 2 to the power of the element width.
- R4: With `sat_en` 1 and `signed_en` 0, an element result below zero becomes 0, and one above the all-ones value becomes all ones.
- R5: With `sat_en` 1 and `signed_en` 1, an element result is clamped to the range from the most negative to the most positive two's-complement value of that width.
- R6: With `sat_en` 0, the value of `signed_en` has no effect on `result`.
- R7: A request sampled with `in_valid` high at a clock edge appears on `result` after that edge, and `out_valid` is high for that one cycle.
- R8: At an edge where `in_valid` is low, `result` keeps its value and `out_valid` goes low.
- R9: While `rst` is high at a clock edge, `result` becomes 0 and `out_valid` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | Packed first operand |
| op_b | input | 64 | Packed second operand |
| opcode | input | 1 | 0 add, 1 subtract (a minus b) |
| lane_sel | input | 2 | Element width select |
| sat_en | input | 1 | 1 clamps, 0 wraps |
| signed_en | input | 1 | 1 signed bounds, 0 unsigned bounds |
| out_valid | output | 1 | Result valid, one cycle after a request |
| result | output | 64 | Packed registered result |

## Verification
The bench targets values that sit on element boundaries: 0xFF plus 1 in every byte, and 0x7F plus 1 or 0x80 minus 1 in signed mode. A design that leaked carries between elements would corrupt the neighbouring element. A design that used the wrong bound would return zero where the signed maximum is expected. Unsigned subtraction that underflows is checked for a zero floor; a wrapping design would return large values instead. Wrap-mode requests are repeated with both signedness settings to catch a sign select that leaks into modulo arithmetic. Idle cycles with changing operands show whether the register updates without a valid request.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DATA_W   = 64;
    localparam int N_WIDTHS = 3;

    typedef enum logic [1:0] {
        LANE_B8   = 2'd0,
        LANE_B16  = 2'd1,
        LANE_B32  = 2'd2,
        LANE_B32X = 2'd3
    } lane_sel_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } alu_op_e;

    typedef struct packed {
        alu_op_e op;
        logic    sat;
        logic    sgn;
    } lane_ctrl_t;

    function automatic int width_of(input int idx);
        return 8 << idx;
    endfunction

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    input  simd_pkg::lane_ctrl_t ctrl,
    output logic [W-1:0]         y
);
    import simd_pkg::*;

    localparam int XW = W + 2;

    logic signed [XW-1:0] ext_a, ext_b, exact;
    logic signed [XW-1:0] s_max, s_min, u_max;

    assign s_max = {2'b00, 1'b0, {(W-1){1'b1}}};
    assign s_min = {2'b11, 1'b1, {(W-1){1'b0}}};
    assign u_max = {2'b00, {W{1'b1}}};

    always_comb begin
        ext_a = {{2{a[W-1] & ctrl.sgn}}, a};
        ext_b = {{2{b[W-1] & ctrl.sgn}}, b};
        exact = (ctrl.op == OP_SUB) ? (ext_a - ext_b) : (ext_a + ext_b);
        y     = exact[W-1:0];
        if (ctrl.sat) begin
            if (ctrl.sgn) begin
                if (exact > s_max)      y = s_max[W-1:0];
                else if (exact < s_min) y = s_min[W-1:0];
            end else begin
                if (exact < 0)          y = '0;
                else if (exact > u_max) y = u_max[W-1:0];
            end
        end
    end

    always_comb begin
        if (ctrl.sat && !ctrl.sgn && ctrl.op == OP_ADD) begin
            AST_USAT_ADD_FLOOR: assert (y >= a) else $error("unsigned clamped add fell below a"); // R4
        end
        if (ctrl.sat && !ctrl.sgn && ctrl.op == OP_SUB) begin
            AST_USAT_SUB_CEIL: assert (y <= a) else $error("unsigned clamped sub rose above a"); // R4
        end
        if (ctrl.sat && ctrl.sgn && ctrl.op == OP_ADD && !a[W-1] && !b[W-1]) begin
            AST_SSAT_NO_FLIP: assert (!y[W-1]) else $error("signed clamped add flipped sign"); // R5
        end
    end

endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank #(
    parameter int W = 8
) (
    input  logic [simd_pkg::DATA_W-1:0] a,
    input  logic [simd_pkg::DATA_W-1:0] b,
    input  simd_pkg::lane_ctrl_t        ctrl,
    output logic [simd_pkg::DATA_W-1:0] y
);
    localparam int N_LANES = simd_pkg::DATA_W / W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        simd_lane_alu #(.W(W)) u_lane (
            .a    (a[i*W +: W]),
            .b    (b[i*W +: W]),
            .ctrl (ctrl),
            .y    (y[i*W +: W])
        );
    end

endmodule

// File: rtl/simd_packed_alu.sv
module simd_packed_alu (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic        opcode,
    input  logic [1:0]  lane_sel,
    input  logic        sat_en,
    input  logic        signed_en,
    output logic        out_valid,
    output logic [63:0] result
);
    import simd_pkg::*;

    lane_ctrl_t        ctrl;
    logic [DATA_W-1:0] bank_y [N_WIDTHS];
    logic [DATA_W-1:0] next_y;

    assign ctrl = '{op: alu_op_e'(opcode), sat: sat_en, sgn: signed_en};

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_bank
        simd_lane_bank #(.W(8 << g)) u_bank (
            .a    (op_a),
            .b    (op_b),
            .ctrl (ctrl),
            .y    (bank_y[g])
        );
    end

    always_comb begin
        case (lane_sel_e'(lane_sel))
            LANE_B8:  next_y = bank_y[0];
            LANE_B16: next_y = bank_y[1];
            default:  next_y = bank_y[2];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_y;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && !out_valid)); // R8

endmodule

// File: tb/simd_packed_alu_tb.sv
module simd_packed_alu_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        opcode = 1'b0;
    logic [1:0]  lane_sel = 2'd0;
    logic        sat_en = 1'b0;
    logic        signed_en = 1'b0;
    logic        out_valid;
    logic [63:0] result;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    simd_packed_alu u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .opcode    (opcode),
        .lane_sel  (lane_sel),
        .sat_en    (sat_en),
        .signed_en (signed_en),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic op, input logic [1:0] ls,
                                          input logic sat, input logic sgn);
        int w;
        logic [63:0] r;
        w = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
        r = '0;
        for (int i = 0; i < 64 / w; i++) begin
            longint mask, xa, xb, s, lo, hi;
            mask = (longint'(1) << w) - 1;
            xa = longint'(a >> (i * w)) & mask;
            xb = longint'(b >> (i * w)) & mask;
            if (sgn) begin
                if (xa >= (longint'(1) << (w - 1))) xa = xa - (longint'(1) << w);
                if (xb >= (longint'(1) << (w - 1))) xb = xb - (longint'(1) << w);
            end
            s = op ? (xa - xb) : (xa + xb);
            if (sat) begin
                if (sgn) begin
                    hi = (longint'(1) << (w - 1)) - 1;
                    lo = -(longint'(1) << (w - 1));
                end else begin
                    hi = mask;
                    lo = 0;
                end
                if (s > hi)      s = hi;
                else if (s < lo) s = lo;
            end
            r = r | (64'(s & mask) << (i * w));
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic op,
                         input logic [1:0] ls, input logic s, input logic sg,
                         input string req);
        @(negedge clk);
        op_a = a; op_b = b; opcode = op; lane_sel = ls; sat_en = s; signed_en = sg;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, result, model(a, b, op, ls, s, sg));
        chk("R7 out_valid", {63'd0, out_valid}, 64'd1);
    endtask

    task automatic idle_check();
        logic [63:0] held;
        held = result;
        @(negedge clk);
        op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
        opcode = ~opcode;
        @(negedge clk);
        chk("R8 hold", result, held);
        chk("R8 out_valid", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R7 act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R9 reset result", result, 64'd0);
        chk("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;

        // R1 R3: every byte wraps to zero, no carry leaks into the next byte
        apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0, 2'd0, 1'b0, 1'b0, "R1 R3 byte wrap");
        chk("R1 literal", result, 64'h0000_0000_0000_0000);
        // R1: same operands as 16-bit lanes carry inside the lane
        apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0, 2'd1, 1'b0, 1'b0, "R1 half lane");
        chk("R1 literal16", result, 64'h0100_0100_0100_0100);
        apply(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 1'b0, 2'd3, 1'b0, 1'b0, "R1 sel3 32-bit");
        chk("R1 literal32", result, 64'h0001_0000_0001_0000);
        // R2: subtract a minus b with wrap
        apply(64'h0005_0005_0005_0005, 64'h0007_0007_0007_0007, 1'b1, 2'd1, 1'b0, 1'b0, "R2 sub");
        chk("R2 literal", result, 64'hFFFE_FFFE_FFFE_FFFE);
        idle_check();
        // R4: unsigned clamps
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1'b0, 2'd0, 1'b1, 1'b0, "R4 usat high");
        chk("R4 literal high", result, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(64'h0001_0001_0001_0001, 64'h0002_0002_0002_0002, 1'b1, 2'd1, 1'b1, 1'b0, "R4 usat low");
        chk("R4 literal low", result, 64'h0);
        // R5: signed clamps
        apply(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 1'b0, 2'd0, 1'b1, 1'b1, "R5 ssat high");
        chk("R5 literal high", result, 64'h7F7F_7F7F_7F7F_7F7F);
        apply(64'h8000_0000_8000_0000, 64'h0000_0001_0000_0001, 1'b1, 2'd2, 1'b1, 1'b1, "R5 ssat low");
        chk("R5 literal low", result, 64'h8000_0000_8000_0000);
        idle_check();
        // R6: signedness ignored in wrap mode
        for (int k = 0; k < 20; k++) begin
            logic [63:0] ra, rb, first;
            logic [1:0] ls;
            logic op;
            ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
            ls = 2'($urandom_range(0, 3)); op = 1'($urandom);
            apply(ra, rb, op, ls, 1'b0, 1'b0, "R6 wrap unsigned");
            first = result;
            apply(ra, rb, op, ls, 1'b0, 1'b1, "R6 wrap signed");
            chk("R6 sign ignored", result, first);
        end
        // R1 R2 R3 R4 R5: random mix
        for (int k = 0; k < 400; k++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
            if (k % 5 == 0) rb = ~ra;
            apply(ra, rb, 1'($urandom), 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                  "R1 R2 R3 R4 R5 random");
            if (k % 50 == 0) idle_check();
        end
        // R9: reset mid-stream clears state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid reset result", result, 64'd0);
        chk("R9 mid reset out_valid", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule